// File: doc/BRIEF.md
# Dual-Port Command Front End

This block is the slave-side entry point of a sequential-access memory. A host sends each command either bit by bit on a serial line (clock idles low or high, data taken on the rising edge) or a whole byte per clock on an 8-bit port. Both ports use the same clock. A port-select input picks which one is live. An active-low select frames each command. Inside the frame the block collects one opcode byte and three address bytes. It then hands a one-cycle command strobe, with the opcode and the 24-bit address, to a downstream controller. After a write-type command, the block passes any further bytes on as a stream of write strobes. After a read command, it shifts bytes that the controller supplies back out on the falling clock edge.

The block enforces hardware write protection. While the protect input is low, program and erase opcodes are swallowed and no strobe is issued. The protection/lockdown opcode family still gets through. An asynchronous active-low reset throws away any frame in progress. The port choice only changes between frames, and only while the controller reports that it is not busy.

Top module: `dual_port_cmd_front`

## Requirements
- R1: No command or write strobe follows a clock edge at which `cs_n` is high. A frame spans the cycles from `cs_n` falling to `cs_n` rising, and only bits or bytes inside that span are taken.
- R2: In serial mode, `si` is sampled on rising edges, most significant bit first. After one opcode byte and three address bytes, `cmd_stb` pulses for exactly one cycle. At the same time `cmd_op` shows the opcode and `cmd_addr` shows the address, with the first address byte in bits 23:16.
- R3: In byte mode, one byte is taken from `pio_in` on every rising edge. The frame is otherwise identical, and `si` is ignored.
- R4: While `cs_n` is high, `so_oe` and `pio_oe` are both low, even in the same cycle as the rise.
- R5: With the latched mode set to serial (`port_sel` = 1), only `so_oe` may be asserted and `pio_in` is ignored. With byte mode (`port_sel` = 0), only `pio_oe` may be asserted.
- R6: `port_sel` is latched only at a rising edge where `cs_n` is high and `busy` is low. Otherwise the previous mode is kept, including across a change of `port_sel` in the middle of a frame. After reset the mode is serial.
- R7: With `wp_n` low, opcodes 0x82 (buffer write and program) and 0x81 (page erase) produce no `cmd_stb` and no `wr_stb` for the rest of the frame. Opcodes outside the set {0x82, 0x81, 0x3D, 0xD2} are dropped the same way whatever `wp_n` is.
- R8: With `wp_n` low, the protection/lockdown opcode 0x3D still produces its `cmd_stb`.
- R9: A frame that ends before all three address bytes are complete issues no strobe. The next frame is parsed from its first byte.
- R10: While `rst_n` is low, any frame in progress is abandoned: bytes that arrived before reset never complete a command.
- R11: After opcode 0xD2 in serial mode, `so` presents `rd_byte` most significant bit first, one bit per clock. Each bit changes on a falling edge. The first bit is valid at the first rising edge after the last address bit.
- R12: After opcode 0xD2 in byte mode, `pio_out` presents `rd_byte` with `pio_oe` high from the first rising edge after the last address byte.
- R13: After a non-read command has been issued, every further byte in the frame gives a one-cycle `wr_stb` with that byte on `wr_data`, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; sample on rise, drive on fall |
| rst_n | input | 1 | Asynchronous active-low reset to idle |
| cs_n | input | 1 | Active-low frame select |
| port_sel | input | 1 | 1 = serial port, 0 = byte port |
| wp_n | input | 1 | Active-low write protect |
| busy | input | 1 | Controller busy; blocks mode changes |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |
| pio_in | input | 8 | Byte port input |
| pio_out | output | 8 | Byte port output |
| pio_oe | output | 8 | Drive enable for `pio_out`, one per bit |
| rd_byte | input | 8 | Read data from controller |
| rd_req | output | 1 | Current read byte consumed |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_op | output | 8 | Opcode of the issued command |
| cmd_addr | output | 24 | Address of the issued command |
| wr_stb | output | 1 | One-cycle write data strobe |
| wr_data | output | 8 | Write data byte |

## Verification
Two things can land on the same rising edge: a change of `port_sel` and an open frame, or a change of `port_sel` and a high `busy`. The bench flips `port_sel` in the middle of a byte-mode frame, and also during a busy interval between frames. It then judges from the strobe and the captured address whether the old mode stayed in force. A second collision is the protect filter against opcode decode: the same opcode is sent with `wp_n` high and then low, and the strobe count must differ only for the guarded opcodes.

// File: rtl/dpcf_pkg.sv
package dpcf_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_PROG       = 8'h82;
  localparam logic [BYTE_W-1:0] OP_PAGE_ERASE = 8'h81;
  localparam logic [BYTE_W-1:0] OP_PROTECT    = 8'h3D;
  localparam logic [BYTE_W-1:0] OP_READ       = 8'hD2;

  typedef enum logic [2:0] {
    PS_OPC,
    PS_ADDR,
    PS_WDATA,
    PS_READ,
    PS_DROP
  } pstate_t;

  // program/erase class, blocked by write protect
  function automatic logic op_guarded(input logic [BYTE_W-1:0] op);
    return (op == OP_PROG) || (op == OP_PAGE_ERASE);
  endfunction

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    return op_guarded(op) || (op == OP_PROTECT) || (op == OP_READ);
  endfunction

  function automatic logic op_is_read(input logic [BYTE_W-1:0] op);
    return op == OP_READ;
  endfunction

  // serial output bit for a given bit slot, msb first
  function automatic logic [2:0] msb_index(input logic [2:0] slot);
    return 3'd7 - slot;
  endfunction
endpackage

// File: rtl/dpcf_deser.sv
module dpcf_deser
  import dpcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              serial_mode,
  input  logic              si,
  input  logic [BYTE_W-1:0] pio_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [2:0]        bit_idx
);
  logic [BYTE_W-2:0] sh_q;
  logic [2:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!sel) begin
      cnt_q <= '0;
    end else if (serial_mode) begin
      sh_q  <= {sh_q[BYTE_W-3:0], si};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign byte_done = sel && (serial_mode ? (cnt_q == 3'd7) : 1'b1);
  assign byte_val  = serial_mode ? {sh_q, si} : pio_in;
  assign bit_idx   = cnt_q;
endmodule

// File: rtl/dpcf_parser.sv
module dpcf_parser
  import dpcf_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wp_n,
  input  logic                     byte_done,
  input  logic [BYTE_W-1:0]        byte_val,
  output logic                     cmd_stb,
  output logic [BYTE_W-1:0]        cmd_op,
  output logic [ADDR_BYTES*8-1:0]  cmd_addr,
  output logic                     wr_stb,
  output logic [BYTE_W-1:0]        wr_data,
  output logic                     in_read,
  output logic                     rd_req
);
  localparam int ADDR_W = ADDR_BYTES * BYTE_W;
  localparam int PREV_W = ADDR_W - BYTE_W;
  localparam int AC_W   = $clog2(ADDR_BYTES);
  localparam logic [AC_W-1:0] LAST_AB = AC_W'(ADDR_BYTES - 1);

  pstate_t           st_q;
  logic [AC_W-1:0]   acnt_q;
  logic [PREV_W-1:0] addr_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_OPC;
      acnt_q    <= '0;
      addr_sh_q <= '0;
      cmd_stb   <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
    end else begin
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (!sel) begin
        st_q   <= PS_OPC;
        acnt_q <= '0;
      end else if (byte_done) begin
        case (st_q)
          PS_OPC: begin
            cmd_op <= byte_val;
            acnt_q <= '0;
            if (!op_known(byte_val) || (op_guarded(byte_val) && !wp_n))
              st_q <= PS_DROP;
            else
              st_q <= PS_ADDR;
          end
          PS_ADDR: begin
            addr_sh_q <= PREV_W'({addr_sh_q, byte_val});
            if (acnt_q == LAST_AB) begin
              cmd_stb  <= 1'b1;
              cmd_addr <= {addr_sh_q, byte_val};
              st_q     <= op_is_read(cmd_op) ? PS_READ : PS_WDATA;
            end else begin
              acnt_q <= acnt_q + 1'b1;
            end
          end
          PS_WDATA: begin
            wr_stb  <= 1'b1;
            wr_data <= byte_val;
          end
          default: ;
        endcase
      end
    end
  end

  assign in_read = (st_q == PS_READ);
  assign rd_req  = byte_done && in_read;

  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_DROP) |=> (!cmd_stb && !wr_stb));

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
endmodule

// File: rtl/dpcf_readout.sv
module dpcf_readout
  import dpcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_read,
  input  logic [2:0]        bit_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              so_q,
  output logic [BYTE_W-1:0] pio_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q  <= 1'b0;
      pio_q <= '0;
    end else if (in_read) begin
      so_q  <= rd_byte[msb_index(bit_idx)];
      pio_q <= rd_byte;
    end
  end
endmodule

// File: rtl/dual_port_cmd_front.sv
module dual_port_cmd_front
  import dpcf_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              port_sel,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [7:0]        pio_in,
  output logic [7:0]        pio_out,
  output logic [7:0]        pio_oe,
  input  logic [7:0]        rd_byte,
  output logic              rd_req,
  output logic              cmd_stb,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_stb,
  output logic [7:0]        wr_data
);
  logic       mode_q;
  logic       sel;
  logic       byte_done;
  logic [7:0] byte_val;
  logic [2:0] bit_idx;
  logic       in_read;
  logic       so_q;
  logic [7:0] pio_q;

  assign sel = !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode_q <= 1'b1;
    else if (cs_n && !busy)  mode_q <= port_sel;
  end

  dpcf_deser u_deser (
    .clk(clk), .rst_n(rst_n), .sel(sel), .serial_mode(mode_q),
    .si(si), .pio_in(pio_in),
    .byte_done(byte_done), .byte_val(byte_val), .bit_idx(bit_idx)
  );

  dpcf_parser #(.ADDR_BYTES(ADDR_BYTES)) u_parser (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wp_n(wp_n),
    .byte_done(byte_done), .byte_val(byte_val),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .in_read(in_read), .rd_req(rd_req)
  );

  dpcf_readout u_readout (
    .clk(clk), .rst_n(rst_n), .in_read(in_read), .bit_idx(bit_idx),
    .rd_byte(rd_byte), .so_q(so_q), .pio_q(pio_q)
  );

  assign so      = so_q;
  assign so_oe   = sel && mode_q && in_read;
  assign pio_out = pio_q;
  assign pio_oe  = {8{sel && !mode_q && in_read}};

  p_quiet_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_stb && !wr_stb));

  p_drivers_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!so_oe && (pio_oe == 8'h00)));

  p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(so_oe && (pio_oe != 8'h00)));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || busy) |=> $stable(mode_q));
endmodule

// File: tb/dual_port_cmd_front_tb.sv
`timescale 1ns/1ps
module dual_port_cmd_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        port_sel = 1'b1;
  logic        wp_n = 1'b1;
  logic        busy = 1'b0;
  logic        si = 1'b0;
  logic        so, so_oe;
  logic [7:0]  pio_in = 8'h00;
  logic [7:0]  pio_out, pio_oe;
  logic [7:0]  rd_byte = 8'h00;
  logic        rd_req;
  logic        cmd_stb;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic        wr_stb;
  logic [7:0]  wr_data;

  always #10 clk = ~clk;

  dual_port_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .port_sel(port_sel), .wp_n(wp_n),
    .busy(busy), .si(si), .so(so), .so_oe(so_oe), .pio_in(pio_in),
    .pio_out(pio_out), .pio_oe(pio_oe), .rd_byte(rd_byte), .rd_req(rd_req),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  int errors = 0;
  int checks = 0;
  int cmd_cnt = 0;
  int wr_cnt = 0;
  logic [7:0]  last_op = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  wr_log [8];
  bit done = 0;

  always @(negedge clk) begin
    if (cmd_stb) begin
      cmd_cnt++;
      last_op = cmd_op;
      last_addr = cmd_addr;
    end
    if (wr_stb) begin
      wr_log[wr_cnt % 8] = wr_data;
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks are entered at a negedge and return at a negedge
  task automatic send_byte(input bit ser, input logic [7:0] b);
    if (ser) begin
      for (int i = 7; i >= 0; i--) begin
        si = b[i];
        pio_in = 8'hFF;
        @(negedge clk);
      end
    end else begin
      pio_in = b;
      si = ~si;
      @(negedge clk);
    end
  endtask

  task automatic send_head(input bit ser, input logic [7:0] op, input logic [23:0] a);
    cs_n = 1'b0;
    send_byte(ser, op);
    send_byte(ser, a[23:16]);
    send_byte(ser, a[15:8]);
    send_byte(ser, a[7:0]);
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input bit m);
    port_sel = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  // {serial, wp_n, opcode, address, strobe expected}
  localparam logic [34:0] VEC [7] = '{
    {1'b1, 1'b1, 8'h82, 24'h123456, 1'b1},
    {1'b1, 1'b0, 8'h82, 24'h654321, 1'b0},
    {1'b1, 1'b0, 8'h3D, 24'h00ABCD, 1'b1},
    {1'b0, 1'b1, 8'hD2, 24'hFEDCBA, 1'b1},
    {1'b0, 1'b0, 8'h81, 24'h000001, 1'b0},
    {1'b0, 1'b0, 8'h3D, 24'h7F0080, 1'b1},
    {1'b1, 1'b1, 8'h55, 24'h0F0F0F, 1'b0}
  };

  initial begin
    int base;
    logic [7:0] got;
    repeat (3) @(negedge clk);
    check(!cmd_stb && !wr_stb && !so_oe && pio_oe == 8'h00, "R10 reset state",
          {cmd_stb, wr_stb, so_oe, pio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R7 R8
    foreach (VEC[k]) begin
      wp_n = VEC[k][33];
      set_mode(VEC[k][34]);
      base = cmd_cnt;
      send_head(VEC[k][34], VEC[k][32:25], VEC[k][24:1]);
      end_frame();
      check((cmd_cnt - base) == int'(VEC[k][0]), "R2/R3/R7/R8 strobe count",
            cmd_cnt - base, VEC[k][0]);
      if (VEC[k][0])
        check(last_op == VEC[k][32:25] && last_addr == VEC[k][24:1],
              "R2/R3 opcode and address", {last_op, last_addr}, {VEC[k][32:25], VEC[k][24:1]});
    end
    wp_n = 1'b1;

    // R11 serial read
    set_mode(1'b1);
    rd_byte = 8'hB4;
    send_head(1'b1, 8'hD2, 24'h000100);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      #5;
      got[7-i] = so;
      if (i == 0) check(so_oe && pio_oe == 8'h00, "R11 R5 serial drivers", {so_oe, pio_oe}, 9'h100);
    end
    check(got == 8'hB4, "R11 serial read byte", got, 8'hB4);
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check(!so_oe && pio_oe == 8'h00, "R4 drivers off on rise", {so_oe, pio_oe}, 0);
    @(negedge clk);
    @(negedge clk);

    // R12 byte read
    set_mode(1'b0);
    rd_byte = 8'h5E;
    send_head(1'b0, 8'hD2, 24'h020304);
    @(posedge clk);
    #5;
    check(pio_out == 8'h5E && pio_oe == 8'hFF && !so_oe, "R12 R5 byte read",
          {so_oe, pio_oe, pio_out}, {1'b0, 8'hFF, 8'h5E});
    @(negedge clk);
    end_frame();
    check(!so_oe && pio_oe == 8'h00, "R4 idle drivers", {so_oe, pio_oe}, 0);

    // R13 write streams, both ports
    set_mode(1'b1);
    base = wr_cnt;
    send_head(1'b1, 8'h82, 24'h001122);
    send_byte(1'b1, 8'hA5);
    send_byte(1'b1, 8'h3C);
    end_frame();
    check(wr_cnt - base == 2 && wr_log[base % 8] == 8'hA5 && wr_log[(base + 1) % 8] == 8'h3C,
          "R13 serial write stream", {wr_log[base % 8], wr_log[(base + 1) % 8]}, 16'hA53C);
    set_mode(1'b0);
    base = wr_cnt;
    send_head(1'b0, 8'h3D, 24'h334455);
    send_byte(1'b0, 8'h11);
    send_byte(1'b0, 8'h22);
    end_frame();
    check(wr_cnt - base == 2 && wr_log[base % 8] == 8'h11 && wr_log[(base + 1) % 8] == 8'h22,
          "R13 byte write stream", {wr_log[base % 8], wr_log[(base + 1) % 8]}, 16'h1122);

    // R7 guarded opcode with payload: no write strobes
    wp_n = 1'b0;
    base = wr_cnt;
    send_head(1'b0, 8'h82, 24'h010203);
    send_byte(1'b0, 8'h77);
    end_frame();
    check(wr_cnt == base, "R7 no write strobes when protected", wr_cnt - base, 0);
    wp_n = 1'b1;

    // R9 early end, then recovery
    set_mode(1'b1);
    base = cmd_cnt;
    cs_n = 1'b0;
    send_byte(1'b1, 8'hD2);
    send_byte(1'b1, 8'h44);
    end_frame();
    check(cmd_cnt == base, "R9 short frame dropped", cmd_cnt - base, 0);
    send_head(1'b1, 8'h3D, 24'hC0FFEE);
    end_frame();
    check(cmd_cnt == base + 1 && last_addr == 24'hC0FFEE, "R9 next frame parsed", last_addr, 24'hC0FFEE);

    // R10 reset mid-frame
    base = cmd_cnt;
    cs_n = 1'b0;
    send_byte(1'b1, 8'h82);
    send_byte(1'b1, 8'h12);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send_byte(1'b1, 8'h34);
    send_byte(1'b1, 8'h56);
    end_frame();
    check(cmd_cnt == base, "R10 aborted frame gives no strobe", cmd_cnt - base, 0);

    // R6 busy blocks mode change
    busy = 1'b1;
    set_mode(1'b0);
    base = cmd_cnt;
    send_head(1'b1, 8'h3D, 24'hABCDEF);
    end_frame();
    check(cmd_cnt == base + 1 && last_addr == 24'hABCDEF, "R6 busy keeps serial mode", last_addr, 24'hABCDEF);
    busy = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R6 mid-frame change ignored (now latched byte mode)
    base = cmd_cnt;
    cs_n = 1'b0;
    send_byte(1'b0, 8'h3D);
    port_sel = 1'b1;
    send_byte(1'b0, 8'h9A);
    send_byte(1'b0, 8'hBC);
    send_byte(1'b0, 8'hDE);
    end_frame();
    check(cmd_cnt == base + 1 && last_addr == 24'h9ABCDE, "R6 mid-frame change kept byte mode",
          last_addr, 24'h9ABCDE);

    // R1 deselected traffic ignored
    base = cmd_cnt;
    for (int i = 0; i < 40; i++) begin
      si = i[0];
      pio_in = 8'h3D;
      @(negedge clk);
    end
    check(cmd_cnt == base, "R1 no command while deselected", cmd_cnt - base, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule